// File: doc/BRIEF.md
# Inter-Processor Command Mailbox

This block carries one-byte commands from a main processor to a slave processor, and it carries one-byte replies back the other way. The main processor writes a command into a latch. That write marks the command as pending and raises a single maskable interrupt line toward the slave. The slave services the interrupt by reading the latched byte, and it then acknowledges by reading its status register. The status read is the only slave action that clears the pending mark. The slave sends a reply by writing a separate reply register, which the main processor reads back.

Each processor has its own synchronous register bus: a select strobe, a write strobe, an address and write data. Both buses run in one clock domain. Every read returns its data one cycle after the strobe, through a registered read port. Any side effect of a read takes place on the same clock edge that captures the read data, so a status read returns the flags as they stood before that read cleared them. The interrupt output is a gate of two registered bits, so it has no path from any bus input in the same cycle.

Top module: `cmd_mailbox`

## Requirements
- R1: A main write (m_sel=1, m_wr=1) at main address 0 latches m_wdata as the command and sets the pending flag. A slave read at slave address 0x27 presents that command on s_rdata in the cycle after the read strobe.
- R2: While the pending flag and bit 0 of the enable register are both 1, intr is high. After an enabled command write, intr is high in the cycle following the write's clock edge.
- R3: A slave read at slave address 0x26 returns the status byte as it stood before the read: bit 0 is command pending, bit 1 is reply valid, bit 2 is overrun, and bits 7:3 are zero. The same read clears the pending flag and the overrun flag. A slave read at 0x27 leaves both flags unchanged.
- R4: Slave address 0x28 is a read/write enable register that resets to 0x00, and only its bit 0 gates intr. While bit 0 is 0, intr stays low but the pending command is kept, so setting bit 0 again raises intr.
- R5: A main command write while a command is already pending replaces the latched command and leaves pending set. It also sets the overrun flag, which stays set until the next slave status read.
- R6: When a main command write and a slave status read fall in the same cycle, the pending flag is 1 after that edge. The overrun flag after that edge equals the pending flag just before it.
- R7: A slave write at 0x27 stores a reply byte and sets reply valid. A main read at main address 0 returns the reply and clears reply valid. A main read at main address 1 returns the same status byte as R3 and has no side effect.
- R8: Reset (rst_n=0) clears the pending, overrun and reply-valid flags, the enable register and both read-data outputs, so intr is low.
- R9: A slave read of any address other than 0x26, 0x27 or 0x28 returns 0x00. A slave write to such an address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both buses |
| rst_n | input | 1 | Active-low synchronous reset |
| m_sel | input | 1 | Main bus access strobe |
| m_wr | input | 1 | Main bus write (1) or read (0) |
| m_addr | input | 1 | Main register offset: 0 is command/reply, 1 is status |
| m_wdata | input | 8 | Main write data |
| m_rdata | output | 8 | Main read data, valid the cycle after a read |
| s_sel | input | 1 | Slave bus access strobe |
| s_wr | input | 1 | Slave bus write (1) or read (0) |
| s_addr | input | 8 | Slave register address |
| s_wdata | input | 8 | Slave write data |
| s_rdata | output | 8 | Slave read data, valid the cycle after a read |
| intr | output | 1 | Maskable interrupt request to the slave |

## Verification
Read data on either bus is due one clock after the strobe edge. The flag changes caused by a write or a status read show on intr in that same following cycle. The bench drives each access at a falling edge, lets exactly one rising edge pass, and samples s_rdata, m_rdata and intr at the next falling edge, which is the first point where both the registered data and the updated flags are settled. Checks on a status read therefore expect the flags from before the read, and the read after it expects the cleared flags. The same-cycle collision is driven as a single cycle in which both strobes are active.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  localparam int unsigned STAT_W = 3;

  typedef struct packed {
    logic overrun;
    logic reply_valid;
    logic cmd_pending;
  } mbx_status_t;

  // Pending flag: a new command write takes priority over a clearing read.
  function automatic logic pend_next(input logic cur, input logic set_ev,
                                     input logic clr_ev);
    if (set_ev) return 1'b1;
    if (clr_ev) return 1'b0;
    return cur;
  endfunction

  // Overrun: a write that lands on a pending command latches the flag.
  function automatic logic ovr_next(input logic cur, input logic pend,
                                    input logic set_ev, input logic clr_ev);
    if (set_ev) return pend | (cur & ~clr_ev);
    if (clr_ev) return 1'b0;
    return cur;
  endfunction

  function automatic mbx_status_t make_status(input logic pend,
                                              input logic rvalid,
                                              input logic ovr);
    mbx_status_t s;
    s.cmd_pending = pend;
    s.reply_valid = rvalid;
    s.overrun     = ovr;
    return s;
  endfunction

endpackage

// File: rtl/mbx_cmd_chan.sv
module mbx_cmd_chan #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ev,
  input  logic [DW-1:0] wdata,
  input  logic          clr_ev,
  output logic [DW-1:0] cmd_q,
  output logic          pend_q,
  output logic          ovr_q
);
  import mbx_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      pend_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (wr_ev) cmd_q <= wdata;
      pend_q <= pend_next(pend_q, wr_ev, clr_ev);
      ovr_q  <= ovr_next(ovr_q, pend_q, wr_ev, clr_ev);
    end
  end
endmodule

// File: rtl/mbx_reply_chan.sv
module mbx_reply_chan #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ev,
  input  logic [DW-1:0] wdata,
  input  logic          rd_ev,
  output logic [DW-1:0] reply_q,
  output logic          valid_q
);
  import mbx_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reply_q <= '0;
      valid_q <= 1'b0;
    end else begin
      if (wr_ev) reply_q <= wdata;
      valid_q <= pend_next(valid_q, wr_ev, rd_ev);
    end
  end
endmodule

// File: rtl/mbx_slave_port.sv
module mbx_slave_port #(
  parameter int unsigned        DW        = 8,
  parameter int unsigned        AW        = 8,
  parameter logic [AW-1:0]      STAT_ADDR = 8'h26,
  parameter logic [AW-1:0]      DATA_ADDR = 8'h27,
  parameter logic [AW-1:0]      IEN_ADDR  = 8'h28
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sel,
  input  logic                       wr,
  input  logic [AW-1:0]              addr,
  input  logic [DW-1:0]              wdata,
  input  logic [mbx_pkg::STAT_W-1:0] status,
  input  logic [DW-1:0]              cmd,
  output logic [DW-1:0]              ien_q,
  output logic                       stat_rd_ev,
  output logic                       reply_wr_ev,
  output logic [DW-1:0]              rdata
);
  import mbx_pkg::*;

  localparam int unsigned PAD_W = DW - STAT_W;

  logic          rd_ev;
  logic          ien_wr_ev;
  logic [DW-1:0] rd_mux;

  assign rd_ev       = sel & ~wr;
  assign stat_rd_ev  = rd_ev & (addr == STAT_ADDR);
  assign reply_wr_ev = sel & wr & (addr == DATA_ADDR);
  assign ien_wr_ev   = sel & wr & (addr == IEN_ADDR);

  always_comb begin
    if (addr == STAT_ADDR)      rd_mux = {{PAD_W{1'b0}}, status};
    else if (addr == DATA_ADDR) rd_mux = cmd;
    else if (addr == IEN_ADDR)  rd_mux = ien_q;
    else                        rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien_q <= '0;
      rdata <= '0;
    end else begin
      if (ien_wr_ev) ien_q <= wdata;
      if (rd_ev)     rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/mbx_main_port.sv
module mbx_main_port #(
  parameter int unsigned   DW       = 8,
  parameter int unsigned   AW       = 1,
  parameter logic [AW-1:0] DATA_OFS = 1'b0,
  parameter logic [AW-1:0] STAT_OFS = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sel,
  input  logic                       wr,
  input  logic [AW-1:0]              addr,
  input  logic [mbx_pkg::STAT_W-1:0] status,
  input  logic [DW-1:0]              reply,
  output logic                       cmd_wr_ev,
  output logic                       reply_rd_ev,
  output logic [DW-1:0]              rdata
);
  import mbx_pkg::*;

  localparam int unsigned PAD_W = DW - STAT_W;

  logic          rd_ev;
  logic [DW-1:0] rd_mux;

  assign rd_ev       = sel & ~wr;
  assign cmd_wr_ev   = sel & wr & (addr == DATA_OFS);
  assign reply_rd_ev = rd_ev & (addr == DATA_OFS);

  always_comb begin
    if (addr == DATA_OFS)      rd_mux = reply;
    else if (addr == STAT_OFS) rd_mux = {{PAD_W{1'b0}}, status};
    else                       rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_ev) rdata <= rd_mux;
  end
endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox #(
  parameter int unsigned DW   = 8,
  parameter int unsigned M_AW = 1,
  parameter int unsigned S_AW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            m_sel,
  input  logic            m_wr,
  input  logic [M_AW-1:0] m_addr,
  input  logic [DW-1:0]   m_wdata,
  output logic [DW-1:0]   m_rdata,
  input  logic            s_sel,
  input  logic            s_wr,
  input  logic [S_AW-1:0] s_addr,
  input  logic [DW-1:0]   s_wdata,
  output logic [DW-1:0]   s_rdata,
  output logic            intr
);
  import mbx_pkg::*;

  // Named internal events, also observed by the bound checker.
  logic          cmd_wr_ev;
  logic          stat_rd_ev;
  logic          reply_wr_ev;
  logic          reply_rd_ev;
  logic          pend_q;
  logic          ovr_q;
  logic          rvalid_q;
  logic          ien_bit;
  logic [DW-1:0] cmd_q;
  logic [DW-1:0] reply_q;
  logic [DW-1:0] ien_q;
  mbx_status_t   status;

  assign status  = make_status(pend_q, rvalid_q, ovr_q);
  assign ien_bit = ien_q[0];
  assign intr    = pend_q & ien_bit;

  mbx_cmd_chan #(.DW(DW)) u_cmd (
    .clk(clk), .rst_n(rst_n), .wr_ev(cmd_wr_ev), .wdata(m_wdata),
    .clr_ev(stat_rd_ev), .cmd_q(cmd_q), .pend_q(pend_q), .ovr_q(ovr_q)
  );

  mbx_reply_chan #(.DW(DW)) u_reply (
    .clk(clk), .rst_n(rst_n), .wr_ev(reply_wr_ev), .wdata(s_wdata),
    .rd_ev(reply_rd_ev), .reply_q(reply_q), .valid_q(rvalid_q)
  );

  mbx_slave_port #(.DW(DW), .AW(S_AW)) u_sport (
    .clk(clk), .rst_n(rst_n), .sel(s_sel), .wr(s_wr), .addr(s_addr),
    .wdata(s_wdata), .status(status), .cmd(cmd_q), .ien_q(ien_q),
    .stat_rd_ev(stat_rd_ev), .reply_wr_ev(reply_wr_ev), .rdata(s_rdata)
  );

  mbx_main_port #(.DW(DW), .AW(M_AW)) u_mport (
    .clk(clk), .rst_n(rst_n), .sel(m_sel), .wr(m_wr), .addr(m_addr),
    .status(status), .reply(reply_q), .cmd_wr_ev(cmd_wr_ev),
    .reply_rd_ev(reply_rd_ev), .rdata(m_rdata)
  );
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker (
  input logic clk,
  input logic rst_n,
  input logic cmd_wr_ev,
  input logic stat_rd_ev,
  input logic reply_wr_ev,
  input logic reply_rd_ev,
  input logic pend_q,
  input logic ovr_q,
  input logic rvalid_q,
  input logic ien_bit,
  input logic intr
);
  AST_CMD_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr_ev |=> pend_q); // R1
  AST_INTR_WHEN_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && ien_bit) |-> intr); // R2
  AST_STAT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd_ev && !cmd_wr_ev) |=> (!pend_q && !ovr_q)); // R3
  AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_rd_ev && !cmd_wr_ev) |=> $stable(pend_q)); // R3
  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    !ien_bit |-> !intr); // R4
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr_ev && pend_q) |=> ovr_q); // R5
  AST_COLLIDE_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr_ev && stat_rd_ev) |=> pend_q); // R6
  AST_REPLY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    reply_wr_ev |=> rvalid_q); // R7
  AST_REPLY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (reply_rd_ev && !reply_wr_ev) |=> !rvalid_q); // R7
  AST_NO_INTR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q |-> !intr); // R8
endmodule

bind cmd_mailbox mbx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wr_ev(cmd_wr_ev), .stat_rd_ev(stat_rd_ev),
  .reply_wr_ev(reply_wr_ev), .reply_rd_ev(reply_rd_ev), .pend_q(pend_q),
  .ovr_q(ovr_q), .rvalid_q(rvalid_q), .ien_bit(ien_bit), .intr(intr)
);

// File: tb/cmd_mailbox_test.sv
module cmd_mailbox_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_sel = 1'b0, m_wr = 1'b0;
  logic [0:0] m_addr = '0;
  logic [7:0] m_wdata = '0;
  logic [7:0] m_rdata;
  logic       s_sel = 1'b0, s_wr = 1'b0;
  logic [7:0] s_addr = '0, s_wdata = '0;
  logic [7:0] s_rdata;
  logic       intr;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  cmd_mailbox uut (
    .clk(clk), .rst_n(rst_n), .m_sel(m_sel), .m_wr(m_wr), .m_addr(m_addr),
    .m_wdata(m_wdata), .m_rdata(m_rdata), .s_sel(s_sel), .s_wr(s_wr),
    .s_addr(s_addr), .s_wdata(s_wdata), .s_rdata(s_rdata), .intr(intr)
  );

  // op: 0 main write, 1 main read, 2 slave write, 3 slave read
  typedef struct packed {
    logic [1:0] op;
    logic [7:0] addr;
    logic [7:0] data;
    logic [7:0] exp;
    logic       exp_intr;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{2'd3, 8'h28, 8'h00, 8'h00, 1'b0, 4'd8}, // R8 enable resets to 0
    '{2'd3, 8'h26, 8'h00, 8'h00, 1'b0, 4'd8}, // R8 status clear
    '{2'd0, 8'h00, 8'hA5, 8'h00, 1'b0, 4'd4}, // R4 masked command
    '{2'd2, 8'h28, 8'h01, 8'h00, 1'b1, 4'd4}, // R4 enable raises kept cmd
    '{2'd3, 8'h27, 8'h00, 8'hA5, 1'b1, 4'd1}, // R1 read cmd, R3 no clear
    '{2'd1, 8'h01, 8'h00, 8'h01, 1'b1, 4'd7}, // R7 main status view
    '{2'd3, 8'h26, 8'h00, 8'h01, 1'b0, 4'd3}, // R3 status clears
    '{2'd3, 8'h26, 8'h00, 8'h00, 1'b0, 4'd3}, // R3 flags gone
    '{2'd0, 8'h00, 8'h11, 8'h00, 1'b1, 4'd2}, // R2 enabled command
    '{2'd0, 8'h00, 8'h22, 8'h00, 1'b1, 4'd5}, // R5 overwrite
    '{2'd3, 8'h26, 8'h00, 8'h05, 1'b0, 4'd5}, // R5 overrun seen
    '{2'd3, 8'h26, 8'h00, 8'h00, 1'b0, 4'd5}, // R5 overrun cleared
    '{2'd3, 8'h27, 8'h00, 8'h22, 1'b0, 4'd5}, // R5 newest command kept
    '{2'd2, 8'h27, 8'h3C, 8'h00, 1'b0, 4'd7}, // R7 reply write
    '{2'd1, 8'h01, 8'h00, 8'h02, 1'b0, 4'd7}, // R7 reply valid
    '{2'd3, 8'h26, 8'h00, 8'h02, 1'b0, 4'd7}, // R7 slave sees reply valid
    '{2'd1, 8'h00, 8'h00, 8'h3C, 1'b0, 4'd7}, // R7 reply data
    '{2'd1, 8'h01, 8'h00, 8'h00, 1'b0, 4'd7}, // R7 reply valid cleared
    '{2'd2, 8'h30, 8'hFF, 8'h00, 1'b0, 4'd9}, // R9 unmapped write
    '{2'd3, 8'h30, 8'h00, 8'h00, 1'b0, 4'd9}, // R9 unmapped read zero
    '{2'd3, 8'h28, 8'h00, 8'h01, 1'b0, 4'd9}, // R9 enable untouched
    '{2'd0, 8'h00, 8'h77, 8'h00, 1'b1, 4'd2}, // R2 raise again
    '{2'd2, 8'h28, 8'h00, 8'h00, 1'b0, 4'd4}, // R4 mask drops intr
    '{2'd3, 8'h26, 8'h00, 8'h01, 1'b0, 4'd4}, // R4 pending kept while masked
    '{2'd2, 8'h28, 8'h01, 8'h00, 1'b0, 4'd3}  // R3 cleared cmd stays low
  };

  task automatic check8(input string tag, input logic [7:0] act,
                        input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic check1(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // Drive at a falling edge, pass one rising edge, release at the next fall.
  task automatic bus_op(input logic [1:0] op, input logic [7:0] addr,
                        input logic [7:0] data);
    @(negedge clk);
    if (op < 2) begin
      m_sel = 1'b1; m_wr = (op == 2'd0); m_addr = addr[0]; m_wdata = data;
    end else begin
      s_sel = 1'b1; s_wr = (op == 2'd2); s_addr = addr; s_wdata = data;
    end
    @(negedge clk);
    m_sel = 1'b0; m_wr = 1'b0; s_sel = 1'b0; s_wr = 1'b0;
  endtask

  task automatic collide(input logic [7:0] cmd);
    @(negedge clk);
    m_sel = 1'b1; m_wr = 1'b1; m_addr = 1'b0; m_wdata = cmd;
    s_sel = 1'b1; s_wr = 1'b0; s_addr = 8'h26;
    @(negedge clk);
    m_sel = 1'b0; m_wr = 1'b0; s_sel = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R8 reset state at the ports
    check1("R8 intr after reset", intr, 1'b0);
    check8("R8 s_rdata after reset", s_rdata, 8'h00);
    check8("R8 m_rdata after reset", m_rdata, 8'h00);

    for (int i = 0; i < NV; i++) begin
      bus_op(VECS[i].op, VECS[i].addr, VECS[i].data);
      if (VECS[i].op == 2'd3)
        check8($sformatf("R%0d vec %0d s_rdata", VECS[i].req, i), s_rdata, VECS[i].exp);
      else if (VECS[i].op == 2'd1)
        check8($sformatf("R%0d vec %0d m_rdata", VECS[i].req, i), m_rdata, VECS[i].exp);
      check1($sformatf("R%0d vec %0d intr", VECS[i].req, i), intr, VECS[i].exp_intr);
    end

    // R6 collision with nothing pending: status shows old flags, write wins.
    collide(8'h55);
    check8("R6 collide idle status", s_rdata, 8'h00);
    check1("R6 collide idle intr", intr, 1'b1);
    // R6 collision with a command pending: overrun latched from old pending.
    collide(8'h99);
    check8("R6 collide busy status", s_rdata, 8'h01);
    check1("R6 collide busy intr", intr, 1'b1);
    bus_op(2'd3, 8'h26, 8'h00);
    check8("R6 overrun after collide", s_rdata, 8'h05);
    check1("R6 intr after status read", intr, 1'b0);
    bus_op(2'd3, 8'h27, 8'h00);
    check8("R6 command from collide", s_rdata, 8'h99);

    // R8 mid-run reset with pending, enable and reply set.
    bus_op(2'd0, 8'h00, 8'h42);
    bus_op(2'd2, 8'h27, 8'h24);
    check1("R8 intr before reset", intr, 1'b1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check1("R8 intr after mid reset", intr, 1'b0);
    check8("R8 s_rdata after mid reset", s_rdata, 8'h00);
    bus_op(2'd3, 8'h26, 8'h00);
    check8("R8 status after mid reset", s_rdata, 8'h00);
    bus_op(2'd3, 8'h28, 8'h00);
    check8("R8 enable after mid reset", s_rdata, 8'h00);
    bus_op(2'd1, 8'h01, 8'h00);
    check8("R8 main status after mid reset", m_rdata, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule